// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block is the distribution stage of a small interrupt controller. It keeps, for each of a parameterised number of interrupt lines, an enable bit, a priority, a CPU target byte and a trigger mode. Software reaches this state over a 32-bit register bus that has separate read and write strobes. Inputs configured as edge-triggered are caught on their rising edge and held pending. Level inputs count as pending for as long as they stay high.

On every cycle the block looks for the most urgent interrupt that is pending, enabled and not already being serviced. It presents that interrupt's ID and priority to a single CPU interface. The CPU acknowledges the presented ID, which marks it active. The CPU later ends the interrupt by naming the ID on an end-of-interrupt strobe, which releases it.

Top module: `intr_distributor`

## Requirements
- R1: After reset, every register reads zero. `irqValid` is 0 and `irqId` is 1023, the spurious ID.
- R2: Bit 0 of the control word at offset 0x000 is the global enable. While it is 0, `irqValid` is 0 and `irqId` is 1023, whatever the inputs are.
- R3: Offset 0x004 reads the line count in units of 32 minus one in bits [4:0] (NUM_IRQ/32-1). It reads the CPU count minus one (zero) in bits [7:5]. All other bits read zero.
- R4: The set-enable word for IDs 32w..32w+31 is at 0x100+4w, and ID i sits at bit i%32. Writing 1 to a bit sets that enable, and writing 0 leaves it as it is. A read returns the current enables.
- R5: The clear-enable word at 0x180+4w uses the same bit layout as R4. Writing 1 to a bit clears that enable, and writing 0 leaves it as it is. A read returns the current enables.
- R6: The priority byte for ID i is held in bits [8(i%4)+7 : 8(i%4)] of the word at 0x400+4(i/4). Only the top five bits of each byte are stored, and the low three bits read as zero, so writing 0xFF reads back 0xF8. A lower value means more urgent.
- R7: The CPU target byte for ID i uses the same layout as R6, but at base 0x800. All eight bits are stored.
- R8: The trigger mode of ID i is bit 2(i%16)+1 of the word at 0xC00+4(i/16). A 1 in that bit selects edge mode and a 0 selects level mode. The even bits read as zero.
- R9: A level input is pending one cycle after it goes high and stops being pending once it is low again. An edge input sets its pending bit on a rising edge, and the bit stays set after the input falls, until the interrupt is acknowledged.
- R10: The presented interrupt is the one with the lowest priority value among those that are pending, enabled and not active. A tie goes to the lowest ID. `irqPrio` shows the stored priority byte. If no interrupt qualifies, `irqValid` is 0 and `irqId` is 1023.
- R11: `ackEn` while `irqValid` is 1 marks the presented ID active and clears its edge pending bit. An active ID is not presented again until `eoiEn` arrives with that ID on `eoiId`.
- R12: Reads of unimplemented offsets, of misaligned addresses, and of words that cover IDs at or above NUM_IRQ return zero. Writes to any of them change nothing.
- R13: `busRdData` takes the addressed word one cycle after `busRdEn` and holds its value in every cycle without `busRdEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 12 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, registered |
| irqIn | input | NUM_IRQ | Interrupt source lines |
| ackEn | input | 1 | CPU acknowledges the presented interrupt |
| eoiEn | input | 1 | CPU ends an interrupt |
| eoiId | input | 10 | ID being ended |
| irqValid | output | 1 | An interrupt is presented |
| irqId | output | 10 | Presented ID, or 1023 |
| irqPrio | output | 8 | Priority byte of the presented ID |

## Verification
The bench sweeps every priority, target and mode word, including the word that lies just past the implemented range. A decoder that lets that word through would alias it onto low IDs, and the bench would see stale or corrupted values read back. Priorities are assigned by formula so that every ID has a twin with an equal value. A comparator that keeps the last equal candidate instead of the first would then present the higher ID. The bench pulses an edge input for one cycle to catch a design that only follows the live level. It also holds a level input high across an acknowledge to catch a design that presents an active interrupt again before its end-of-interrupt.

// File: rtl/intr_dist_pkg.sv
package intr_dist_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_SETEN, RG_CLREN, RG_PRIO, RG_TGT, RG_CFG
  } regionE;

  typedef struct packed {
    logic   wr;
    logic   rd;
    regionE region;
    logic [7:0] idx;
  } busCmdT;
endpackage

// File: rtl/intr_dist_ctrl.sv
module intr_dist_ctrl
  import intr_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic [11:0] busAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  output busCmdT      cmd
);
  localparam int EN_WORDS   = NUM_IRQ / 32;
  localparam int BYTE_WORDS = NUM_IRQ / 4;
  localparam int CFG_WORDS  = NUM_IRQ / 16;

  always_comb begin
    cmd.wr     = busWrEn;
    cmd.rd     = busRdEn;
    cmd.region = RG_NONE;
    cmd.idx    = '0;
    if (busAddr[1:0] == 2'b00) begin
      if (busAddr[11:2] == 10'd0) begin
        cmd.region = RG_CTRL;
      end else if (busAddr[11:2] == 10'd1) begin
        cmd.region = RG_TYPE;
      end else if (busAddr[11:7] == 5'b00010) begin
        if (int'(busAddr[6:2]) < EN_WORDS) begin
          cmd.region = RG_SETEN;
          cmd.idx    = {3'b000, busAddr[6:2]};
        end
      end else if (busAddr[11:7] == 5'b00011) begin
        if (int'(busAddr[6:2]) < EN_WORDS) begin
          cmd.region = RG_CLREN;
          cmd.idx    = {3'b000, busAddr[6:2]};
        end
      end else begin
        case (busAddr[11:10])
          2'b01: if (int'(busAddr[9:2]) < BYTE_WORDS) begin
            cmd.region = RG_PRIO;
            cmd.idx    = busAddr[9:2];
          end
          2'b10: if (int'(busAddr[9:2]) < BYTE_WORDS) begin
            cmd.region = RG_TGT;
            cmd.idx    = busAddr[9:2];
          end
          2'b11: if (int'(busAddr[9:2]) < CFG_WORDS) begin
            cmd.region = RG_CFG;
            cmd.idx    = busAddr[9:2];
          end
          default: cmd.region = RG_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/intr_dist_arb.sv
module intr_dist_arb
  import intr_dist_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 5
) (
  input  logic [NUM_IRQ-1:0]                candVec,
  input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prioVec,
  output logic                              found,
  output logic [ID_W-1:0]                   bestId,
  output logic [PRIO_BITS-1:0]              bestPrio
);
  always_comb begin
    found    = 1'b0;
    bestId   = SPURIOUS_ID;
    bestPrio = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      // strict compare keeps the lowest ID on a tie
      if (candVec[i] && (!found || prioVec[i] < bestPrio)) begin
        found    = 1'b1;
        bestId   = ID_W'(i);
        bestPrio = prioVec[i];
      end
    end
  end
endmodule

// File: rtl/intr_dist_regs.sv
module intr_dist_regs
  import intr_dist_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 5
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  busCmdT                            cmd,
  input  logic [31:0]                       wrData,
  input  logic [NUM_IRQ-1:0]                irqIn,
  input  logic                              ackFire,
  input  logic [ID_W-1:0]                   ackId,
  input  logic                              eoiEn,
  input  logic [ID_W-1:0]                   eoiId,
  output logic                              ctrlEn,
  output logic [NUM_IRQ-1:0]                candVec,
  output logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prioVec,
  output logic [31:0]                       rdData
);
  localparam int PRIO_SHIFT = 8 - PRIO_BITS;
  localparam logic [4:0] LINE_FIELD = 5'(NUM_IRQ / 32 - 1);

  logic [NUM_IRQ-1:0]          enableQ, edgeCfgQ, edgePendQ, activeQ;
  logic [NUM_IRQ-1:0]          irqSyncQ, irqPrevQ;
  logic [NUM_IRQ-1:0][7:0]     targetQ;
  logic [31:0]                 rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      irqSyncQ <= '0;
      irqPrevQ <= '0;
      rdData   <= '0;
    end else begin
      if (cmd.wr && cmd.region == RG_CTRL) ctrlEn <= wrData[0];
      irqSyncQ <= irqIn;
      irqPrevQ <= irqSyncQ;
      if (cmd.rd) rdData <= rdNext;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    localparam int W32 = i / 32;
    localparam int B32 = i % 32;
    localparam int W4  = i / 4;
    localparam int B4  = i % 4;
    localparam int W16 = i / 16;
    localparam int B16 = i % 16;

    logic ackHit, eoiHit, riseHit;
    assign ackHit  = ackFire && (ackId == ID_W'(i));
    assign eoiHit  = eoiEn && (eoiId == ID_W'(i));
    assign riseHit = edgeCfgQ[i] && irqSyncQ[i] && !irqPrevQ[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enableQ[i]   <= 1'b0;
        prioVec[i]   <= '0;
        targetQ[i]   <= '0;
        edgeCfgQ[i]  <= 1'b0;
        edgePendQ[i] <= 1'b0;
        activeQ[i]   <= 1'b0;
      end else begin
        if (cmd.wr && cmd.idx == 8'(W32) && wrData[B32]) begin
          if (cmd.region == RG_SETEN) enableQ[i] <= 1'b1;
          if (cmd.region == RG_CLREN) enableQ[i] <= 1'b0;
        end
        if (cmd.wr && cmd.idx == 8'(W4)) begin
          if (cmd.region == RG_PRIO) prioVec[i] <= wrData[8*B4+7 -: PRIO_BITS];
          if (cmd.region == RG_TGT)  targetQ[i] <= wrData[8*B4 +: 8];
        end
        if (cmd.wr && cmd.region == RG_CFG && cmd.idx == 8'(W16))
          edgeCfgQ[i] <= wrData[2*B16+1];
        if (ackHit)  edgePendQ[i] <= 1'b0;
        if (riseHit) edgePendQ[i] <= 1'b1;
        if (eoiHit)  activeQ[i]   <= 1'b0;
        if (ackHit)  activeQ[i]   <= 1'b1;
      end
    end

    assign candVec[i] = enableQ[i] && !activeQ[i] &&
                        (edgeCfgQ[i] ? edgePendQ[i] : irqSyncQ[i]);
  end

  always_comb begin
    rdNext = '0;
    case (cmd.region)
      RG_CTRL: rdNext[0] = ctrlEn;
      RG_TYPE: rdNext[4:0] = LINE_FIELD;
      default: begin
        for (int i = 0; i < NUM_IRQ; i++) begin
          if ((cmd.region == RG_SETEN || cmd.region == RG_CLREN) && cmd.idx == 8'(i / 32))
            rdNext[i % 32] = enableQ[i];
          if (cmd.region == RG_PRIO && cmd.idx == 8'(i / 4))
            rdNext[8*(i%4) +: 8] = 8'(prioVec[i]) << PRIO_SHIFT;
          if (cmd.region == RG_TGT && cmd.idx == 8'(i / 4))
            rdNext[8*(i%4) +: 8] = targetQ[i];
          if (cmd.region == RG_CFG && cmd.idx == 8'(i / 16))
            rdNext[2*(i%16)+1] = edgeCfgQ[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/intr_distributor.sv
module intr_distributor
  import intr_dist_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [11:0]        busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  input  logic               busRdEn,
  output logic [31:0]        busRdData,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               ackEn,
  input  logic               eoiEn,
  input  logic [9:0]         eoiId,
  output logic               irqValid,
  output logic [9:0]         irqId,
  output logic [7:0]         irqPrio
);
  busCmdT                            cmd;
  logic                              ctrlEn, found;
  logic [NUM_IRQ-1:0]                candVec;
  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prioVec;
  logic [ID_W-1:0]                   bestId;
  logic [PRIO_BITS-1:0]              bestPrio;

  intr_dist_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .cmd(cmd)
  );

  intr_dist_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_regs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(busWrData), .irqIn(irqIn),
    .ackFire(ackEn && irqValid), .ackId(irqId), .eoiEn(eoiEn), .eoiId(eoiId),
    .ctrlEn(ctrlEn), .candVec(candVec), .prioVec(prioVec), .rdData(busRdData)
  );

  intr_dist_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_arb (
    .candVec(candVec), .prioVec(prioVec),
    .found(found), .bestId(bestId), .bestPrio(bestPrio)
  );

  assign irqValid = ctrlEn && found;
  assign irqId    = irqValid ? bestId : SPURIOUS_ID;
  assign irqPrio  = irqValid ? (8'(bestPrio) << (8 - PRIO_BITS)) : 8'd0;
endmodule

// File: rtl/intr_dist_chk.sv
module intr_dist_chk #(
  parameter int NUM_IRQ = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic [11:0] busAddr,
  input logic        busWrEn,
  input logic [31:0] busWrData,
  input logic        busRdEn,
  input logic [31:0] busRdData,
  input logic        ackEn,
  input logic        eoiEn,
  input logic        irqValid,
  input logic [9:0]  irqId,
  input logic [7:0]  irqPrio
);
  p_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 12'h000 && !busWrData[0]) |=> !irqValid);

  p_prio_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> irqPrio[2:0] == 3'b000);

  p_spurious_r10: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> irqId == 10'd1023);

  p_id_range_r12: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> int'(irqId) < NUM_IRQ);

  p_ack_drops_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ackEn && irqValid && !eoiEn) |=> (!irqValid || irqId != $past(irqId)));

  p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData));
endmodule

bind intr_distributor intr_dist_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
  .ackEn(ackEn), .eoiEn(eoiEn), .irqValid(irqValid), .irqId(irqId),
  .irqPrio(irqPrio)
);

// File: tb/intr_distributor_tb.sv
module intr_distributor_tb;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic [N-1:0] irqIn = '0;
  logic        ackEn = 1'b0;
  logic        eoiEn = 1'b0;
  logic [9:0]  eoiId = '0;
  logic        irqValid;
  logic [9:0]  irqId;
  logic [7:0]  irqPrio;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  logic [7:0] prM [N];
  logic [N-1:0] enM;

  always #2 clk = ~clk;

  intr_distributor #(.NUM_IRQ(N), .PRIO_BITS(5)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .irqIn(irqIn), .ackEn(ackEn), .eoiEn(eoiEn), .eoiId(eoiId),
    .irqValid(irqValid), .irqId(irqId), .irqPrio(irqPrio)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRdEn = 1'b1;
    @(negedge clk); busRdEn = 1'b0; d = busRdData;
  endtask

  task automatic readCheck(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    check(req, d, exp);
  endtask

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [9:0] modelId(input logic [N-1:0] pat);
    logic f = 1'b0;
    logic [7:0] bp = '0;
    logic [9:0] id = 10'd1023;
    for (int i = 0; i < N; i++)
      if (pat[i] && enM[i] && (!f || prM[i] < bp)) begin
        f = 1'b1; bp = prM[i]; id = 10'(i);
      end
    return id;
  endfunction

  task automatic checkSel(input string req, input logic [N-1:0] pat);
    logic [9:0] e = modelId(pat);
    check(req, {22'd0, irqId}, {22'd0, e});
    check(req, {31'd0, irqValid}, {31'd0, e != 10'd1023});
    if (e != 10'd1023) check(req, {24'd0, irqPrio}, {24'd0, prM[e]});
  endtask

  task automatic pulse(input bit isAck, input logic [9:0] id);
    @(negedge clk);
    if (isAck) ackEn = 1'b1; else begin eoiEn = 1'b1; eoiId = id; end
    @(negedge clk); ackEn = 1'b0; eoiEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, p2;
    logic [N-1:0] lfsr;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    check("R1", {31'd0, irqValid}, 32'd0);
    check("R1", {22'd0, irqId}, 32'd1023);
    readCheck("R1", 12'h000, 0);
    readCheck("R1", 12'h100, 0);
    readCheck("R1", 12'h400, 0);
    readCheck("R1", 12'h800, 0);
    readCheck("R1", 12'hC00, 0);
    // R3 type word
    readCheck("R3", 12'h004, 32'd1);
    // R13 read data holds during a write
    busWrite(12'h800, 32'h1234_5678);
    check("R13", busRdData, 32'd1);
    waitCyc(2);
    check("R13", busRdData, 32'd1);
    // R4, R5 enable banks
    for (int w = 0; w < 2; w++) begin
      v  = 32'hA5C3_0F96 ^ (32'(w) * 32'h1357_9BDF);
      p2 = 32'h0F0F_0F0F;
      busWrite(12'h100 + 12'(4*w), v);
      readCheck("R4", 12'h100 + 12'(4*w), v);
      readCheck("R5", 12'h180 + 12'(4*w), v);
      busWrite(12'h100 + 12'(4*w), 0);
      readCheck("R4", 12'h100 + 12'(4*w), v);
      busWrite(12'h180 + 12'(4*w), p2);
      readCheck("R5", 12'h180 + 12'(4*w), v & ~p2);
      busWrite(12'h180 + 12'(4*w), 0);
      readCheck("R5", 12'h100 + 12'(4*w), v & ~p2);
      busWrite(12'h180 + 12'(4*w), 32'hFFFF_FFFF);
      readCheck("R5", 12'h100 + 12'(4*w), 0);
    end
    // R6 priority sweep
    for (int k = 0; k < 16; k++) begin
      v = (32'(k) * 32'h0411_0923) ^ 32'h9C3E_57A1;
      busWrite(12'h400 + 12'(4*k), v);
      readCheck("R6", 12'h400 + 12'(4*k), v & 32'hF8F8_F8F8);
    end
    busWrite(12'h400, 32'hFFFF_FFFF);
    readCheck("R6", 12'h400, 32'hF8F8_F8F8);
    // R7 target sweep
    for (int k = 0; k < 16; k++) begin
      v = (32'(k) * 32'h2A51_1C07) ^ 32'h6B3D_E0F4;
      busWrite(12'h800 + 12'(4*k), v);
      readCheck("R7", 12'h800 + 12'(4*k), v);
    end
    // R8 configuration sweep
    for (int k = 0; k < 4; k++) begin
      v = 32'hFFFF_FFFF ^ (32'(k) * 32'h0101_0303);
      busWrite(12'hC00 + 12'(4*k), v);
      readCheck("R8", 12'hC00 + 12'(4*k), v & 32'hAAAA_AAAA);
    end
    // R12 out of range and unimplemented
    busWrite(12'h108, 32'hFFFF_FFFF);
    readCheck("R12", 12'h108, 0);
    readCheck("R12", 12'h100, 0);
    readCheck("R12", 12'h104, 0);
    busWrite(12'h440, 32'hFFFF_FFFF);
    readCheck("R12", 12'h440, 0);
    busWrite(12'h840, 32'hFFFF_FFFF);
    readCheck("R12", 12'h840, 0);
    busWrite(12'hC10, 32'hFFFF_FFFF);
    readCheck("R12", 12'hC10, 0);
    readCheck("R12", 12'h200, 0);
    busWrite(12'h401, 32'h0);
    readCheck("R12", 12'h400, 32'hF8F8_F8F8);

    // arbitration setup: level mode, formula priorities, some lines disabled
    for (int k = 0; k < 4; k++) busWrite(12'hC00 + 12'(4*k), 0);
    for (int i = 0; i < N; i++) prM[i] = 8'(((i * 37 + 11) % 32) << 3);
    for (int k = 0; k < 16; k++)
      busWrite(12'h400 + 12'(4*k), {prM[4*k+3], prM[4*k+2], prM[4*k+1], prM[4*k]});
    for (int i = 0; i < N; i++) enM[i] = (i % 7 != 3);
    busWrite(12'h100, enM[31:0]);
    busWrite(12'h104, enM[63:32]);
    busWrite(12'h000, 32'd1);
    // R10 nothing pending
    waitCyc(2);
    checkSel("R10", '0);
    // R9, R10 single line sweep
    for (int i = 0; i < N; i++) begin
      @(negedge clk); irqIn = N'(1) << i;
      waitCyc(1);
      checkSel("R9", irqIn);
    end
    // R10 patterns
    lfsr = 64'hACE1_2468_9BDF_1357;
    for (int t = 0; t < 40; t++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      @(negedge clk); irqIn = lfsr & (t[0] ? {lfsr[31:0], lfsr[63:32]} : '1);
      waitCyc(1);
      checkSel("R10", irqIn);
    end
    // R10 tie between 4 and 36 (equal priority)
    @(negedge clk); irqIn = (N'(1) << 4) | (N'(1) << 36);
    waitCyc(1);
    check("R10", {22'd0, irqId}, 32'd4);
    // R2 global enable off
    busWrite(12'h000, 32'd0);
    check("R2", {31'd0, irqValid}, 32'd0);
    check("R2", {22'd0, irqId}, 32'd1023);
    busWrite(12'h000, 32'd1);
    check("R2", {22'd0, irqId}, 32'd4);
    @(negedge clk); irqIn = '0;
    waitCyc(2);
    // R9 edge line 5 (bit 11 of config word 0)
    busWrite(12'hC00, 32'h0000_0800);
    @(negedge clk); irqIn[5] = 1'b1;
    @(negedge clk); irqIn[5] = 1'b0;
    waitCyc(3);
    check("R9", {22'd0, irqId}, 32'd5);
    // R11 acknowledge clears edge pending and marks active
    pulse(1'b1, 0);
    check("R11", {31'd0, irqValid}, 32'd0);
    pulse(1'b0, 10'd5);
    waitCyc(1);
    check("R11", {31'd0, irqValid}, 32'd0);
    // R11 level line 8 held high across acknowledge
    @(negedge clk); irqIn[8] = 1'b1;
    waitCyc(1);
    check("R9", {22'd0, irqId}, 32'd8);
    pulse(1'b1, 0);
    waitCyc(2);
    check("R11", {31'd0, irqValid}, 32'd0);
    pulse(1'b0, 10'd8);
    check("R11", {22'd0, irqId}, 32'd8);
    @(negedge clk); irqIn[8] = 1'b0;
    waitCyc(1);
    check("R9", {31'd0, irqValid}, 32'd0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule